// File: doc/BRIEF.md
# Static Memory Access Timing Engine

This block is the static-memory half of a memory controller. It takes one read or write at a time from a host-side valid/ready request port and plays it out on the pins of an external asynchronous memory or peripheral. It drives chip select, output enable, write enable, byte-lane selects, the address, and a write-data bus with its drive enable. Each phase of the access is counted in clock cycles from configuration inputs. These inputs set the delay from chip select to output enable and to write enable, the read wait for the first word, a shorter wait for later words of a page read, the write wait, and an idle gap between accesses.

A read request may ask for up to four consecutive words. In page mode the first word uses the full read wait and the others use the page wait, while chip select and output enable stay asserted and the address steps by the memory width. The chip-select polarity and the byte-lane polarity can be set. An active-low wait input can hold the final cycle of any word. A counter with 16-cycle granularity ends a held access that never gets released, and flags its response.

Configuration inputs must be held steady while an access is in flight. The host sees one response pulse per word transferred.

Top module: `smc_timing`

## Requirements
- R1: For a single read, chip select is asserted for max(cfg_rd_wait, cfg_cs_to_oe)+1 cycles, and output enable asserts exactly cfg_cs_to_oe cycles after chip select (together with it when the field is 0) and stays on until chip select drops.
- R2: For a write, write enable asserts cfg_cs_to_we+1 cycles after chip select and stays on for cfg_wr_wait+2 cycles. It drops in the same cycle as chip select. Write data is driven (mem_dq_oe=1) for the whole time chip select is on, and never while output enable is on.
- R3: A read with req_len=n transfers n+1 words under one chip select. With cfg_page_en=1, words after the first each last cfg_pg_wait+1 cycles. With cfg_page_en=0, every word takes the first-word length from R1.
- R4: cfg_width code 0 is 8-bit (address step 1, lane mask 0001), code 1 is 16-bit (step 2, mask 0011), and codes 2 and 3 are 32-bit (step 4, mask 1111). Read data is returned with the byte lanes outside the mask forced to zero.
- R5: After chip select drops, req_ready stays low for exactly cfg_turn+1 cycles. req_ready is never high while chip select is asserted.
- R6: cfg_cs_high=0 makes mem_cs active low; cfg_cs_high=1 makes it active high.
- R7: With cfg_lane_low=1, mem_lane is all ones except while a strobe is on: during output enable it shows the inverted width mask, and during write enable it shows the inverted req_be. With cfg_lane_low=0, the width mask shows true during output enable and the pins are 0 otherwise. The exception is a write access with chip select on, where the pins idle at all ones and show the inverted req_be during write enable.
- R8: With cfg_ext_wait=1, a word whose final cycle sees mem_wait_n low stays in that cycle, and it finishes in the first cycle in which mem_wait_n is high.
- R9: If mem_wait_n is still low after 16*(cfg_wait_to+1) cycles in the held final cycle, the word ends with rsp_timeout=1 and rsp_last=1, and any remaining words of the read are dropped.
- R10: With cfg_ext_wait=0, mem_wait_n has no effect on the timing of any access.
- R11: rsp_valid pulses for one cycle after each word ends: once per read word and once per write. For reads, rsp_rdata holds the data bus as sampled in that word's final cycle. rsp_last is 1 only on the final response of a request.
- R12: Output enable and write enable are never asserted together. After reset, chip select is inactive, both strobes are high, mem_dq_oe is 0, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_high | input | 1 | Chip-select polarity, 1 = active high |
| cfg_lane_low | input | 1 | Byte-lane polarity select (see R7) |
| cfg_page_en | input | 1 | Page-mode reads on |
| cfg_ext_wait | input | 1 | Honour mem_wait_n |
| cfg_width | input | 2 | Memory width code |
| cfg_cs_to_oe | input | 4 | Cycles from chip select to output enable |
| cfg_cs_to_we | input | 4 | Write-enable delay minus one |
| cfg_rd_wait | input | 5 | First-word read length minus one |
| cfg_pg_wait | input | 5 | Later page-word length minus one |
| cfg_wr_wait | input | 5 | Write-enable width minus two |
| cfg_turn | input | 4 | Gap between accesses minus one |
| cfg_wait_to | input | 10 | Wait timeout in 16-cycle units minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Extra read words (ignored on writes) |
| req_addr | input | AW | Byte address of first word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| rsp_valid | output | 1 | Word completed |
| rsp_last | output | 1 | Final response of the request |
| rsp_timeout | output | 1 | Word ended by wait timeout |
| rsp_rdata | output | 32 | Read data |
| mem_cs | output | 1 | Chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane | output | 4 | Byte-lane selects |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 32 | Write data to memory |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_in | input | 32 | Read data from memory |
| mem_wait_n | input | 1 | Wait request, active low |

## Verification
The bench sweeps the delay, wait and turnaround fields over small ranges, counts every phase at the pins and compares the counts with the formulas above. An off-by-one in the write offset of two, or in the turnaround, shows up as a cycle-count mismatch. Output enable that waits one cycle too long at a zero delay does the same. Page reads with and without page mode separate a design that always applies the shorter wait, or never applies it. Per-word data checks at every width catch a wrong address step or unmasked lanes. The wait tests release the wait input exactly on the last cycle before the timeout and exactly on it, and hold it forever during a burst. A design whose timeout is one cycle off, that lets a release beat the timeout in the wrong order, or that keeps bursting after a timeout, gives the wrong length, the wrong flag or the wrong response count.

// File: rtl/smc_timing.sv
module smc_timing #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cs_high,
  input  logic          cfg_lane_low,
  input  logic          cfg_page_en,
  input  logic          cfg_ext_wait,
  input  logic [1:0]    cfg_width,
  input  logic [3:0]    cfg_cs_to_oe,
  input  logic [3:0]    cfg_cs_to_we,
  input  logic [4:0]    cfg_rd_wait,
  input  logic [4:0]    cfg_pg_wait,
  input  logic [4:0]    cfg_wr_wait,
  input  logic [3:0]    cfg_turn,
  input  logic [9:0]    cfg_wait_to,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_len,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_be,
  output logic          rsp_valid,
  output logic          rsp_last,
  output logic          rsp_timeout,
  output logic [31:0]   rsp_rdata,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [3:0]    mem_lane,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [31:0]   mem_dq_in,
  input  logic          mem_wait_n
);

  localparam int CW = 7;
  localparam int HW = 14;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_TURN} st_t;

  st_t            st;
  logic           wr_q;
  logic [1:0]     len_q, widx;
  logic [AW-1:0]  addr_q;
  logic [31:0]    wdata_q;
  logic [3:0]     be_q;
  logic [CW-1:0]  cyc;
  logic [HW-1:0]  hold;

  logic [CW-1:0]  first_idx, wr_idx, last_idx;
  logic [HW-1:0]  hold_lim;
  logic           cs_act, oe_act, we_act;
  logic           at_last, stall, tmo, word_end, final_word;
  logic [3:0]     wmask, lane_on;
  logic [31:0]    lane_bits;
  logic [1:0]     step_sh;

  assign first_idx = (cfg_rd_wait >= {1'b0, cfg_cs_to_oe}) ? CW'(cfg_rd_wait) : CW'(cfg_cs_to_oe);
  assign wr_idx    = CW'(cfg_cs_to_we) + CW'(cfg_wr_wait) + CW'(2);
  assign last_idx  = wr_q ? wr_idx :
                     (cfg_page_en && widx != 2'd0) ? CW'(cfg_pg_wait) : first_idx;
  assign hold_lim  = {cfg_wait_to, 4'hF};

  assign cs_act     = (st == S_ACC);
  assign at_last    = cs_act && (cyc == last_idx);
  assign stall      = at_last && cfg_ext_wait && !mem_wait_n;
  assign tmo        = stall && (hold == hold_lim);
  assign word_end   = at_last && (!stall || tmo);
  assign final_word = wr_q || tmo || (widx == len_q);

  assign oe_act = cs_act && !wr_q && (widx != 2'd0 || cyc >= CW'(cfg_cs_to_oe));
  assign we_act = cs_act && wr_q && (cyc > CW'(cfg_cs_to_we));

  assign wmask     = (cfg_width == 2'd0) ? 4'b0001 : (cfg_width == 2'd1) ? 4'b0011 : 4'b1111;
  assign step_sh   = (cfg_width == 2'd0) ? 2'd0 : (cfg_width == 2'd1) ? 2'd1 : 2'd2;
  assign lane_bits = {{8{wmask[3]}}, {8{wmask[2]}}, {8{wmask[1]}}, {8{wmask[0]}}};
  assign lane_on   = oe_act ? wmask : (we_act ? be_q : 4'b0000);

  assign req_ready  = (st == S_IDLE);
  assign mem_cs     = cfg_cs_high ? cs_act : !cs_act;
  assign mem_oe_n   = !oe_act;
  assign mem_we_n   = !we_act;
  assign mem_lane   = (cfg_lane_low || (cs_act && wr_q)) ? ~lane_on : lane_on;
  assign mem_addr   = addr_q + (AW'(widx) << step_sh);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = cs_act && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      wr_q        <= 1'b0;
      len_q       <= '0;
      widx        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      cyc         <= '0;
      hold        <= '0;
      rsp_valid   <= 1'b0;
      rsp_last    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st      <= S_ACC;
            wr_q    <= req_write;
            len_q   <= req_write ? 2'd0 : req_len;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            widx    <= '0;
            cyc     <= '0;
            hold    <= '0;
          end
        end
        S_ACC: begin
          if (word_end) begin
            rsp_valid   <= 1'b1;
            rsp_last    <= final_word;
            rsp_timeout <= tmo;
            rsp_rdata   <= wr_q ? 32'h0 : (mem_dq_in & lane_bits);
            hold        <= '0;
            cyc         <= '0;
            if (final_word) st <= S_TURN;
            else widx <= widx + 2'd1;
          end else if (stall) begin
            hold <= hold + HW'(1);
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        default: begin
          if (cyc == CW'(cfg_turn)) st <= S_IDLE;
          else cyc <= cyc + CW'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/smc_timing_chk.sv
module smc_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cs_high,
  input logic mem_cs,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe,
  input logic req_ready,
  input logic rsp_valid
);

  logic cs_on;
  assign cs_on = (mem_cs == cfg_cs_high);

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r1_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> cs_on);

  a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> cs_on);

  a_r2_we_ends_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !cs_on);

  a_r2_drive_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && cs_on));

  a_r5_not_ready_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cs_on);

  a_r5_gap_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on) |-> !req_ready);

  a_r11_rsp_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cs_on));

endmodule

bind smc_timing smc_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cs_high(cfg_cs_high), .mem_cs(mem_cs),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/smc_timing_bench.sv
`timescale 1ns/1ps
module smc_timing_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_cs_high = 0, cfg_lane_low = 0, cfg_page_en = 0, cfg_ext_wait = 0;
  logic [1:0] cfg_width = 0;
  logic [3:0] cfg_cs_to_oe = 0, cfg_cs_to_we = 0, cfg_turn = 0;
  logic [4:0] cfg_rd_wait = 0, cfg_pg_wait = 0, cfg_wr_wait = 0;
  logic [9:0] cfg_wait_to = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_len = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0] req_be = 0;
  logic req_ready, rsp_valid, rsp_last, rsp_timeout;
  logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0] mem_lane;
  logic [15:0] mem_addr;
  logic mem_wait_n = 1;

  int checks = 0, errors = 0;

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  assign mem_dq_in = pat(mem_addr);

  smc_timing #(.AW(16)) u_smc_timing (
    .clk(clk), .rst_n(rst_n),
    .cfg_cs_high(cfg_cs_high), .cfg_lane_low(cfg_lane_low), .cfg_page_en(cfg_page_en),
    .cfg_ext_wait(cfg_ext_wait), .cfg_width(cfg_width), .cfg_cs_to_oe(cfg_cs_to_oe),
    .cfg_cs_to_we(cfg_cs_to_we), .cfg_rd_wait(cfg_rd_wait), .cfg_pg_wait(cfg_pg_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_turn(cfg_turn), .cfg_wait_to(cfg_wait_to),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_len(req_len),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane(mem_lane),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic wr, input logic [1:0] len,
                        input logic [15:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input int wrel);
    int last, lp, tt, e, exp_cs, exp_rsp, step;
    int cs_n = 0, oe_f = -1, we_f = -1, we_n = 0, turn_n = 0, rsp_n = 0, k = 0;
    bit exp_tmo = 0, tmo_seen = 0, bad_bus = 0, bad_data = 0, bad_last = 0, cs;
    logic [3:0] wm, exp_lane;
    logic [31:0] lb, exp_d;
    step = (cfg_width == 0) ? 1 : (cfg_width == 1) ? 2 : 4;
    wm   = (cfg_width == 0) ? 4'b0001 : (cfg_width == 1) ? 4'b0011 : 4'b1111;
    lb   = {{8{wm[3]}}, {8{wm[2]}}, {8{wm[1]}}, {8{wm[0]}}};
    tt   = 16 * (int'(cfg_wait_to) + 1);
    if (wr) last = int'(cfg_cs_to_we) + int'(cfg_wr_wait) + 2;
    else last = (int'(cfg_rd_wait) > int'(cfg_cs_to_oe)) ? int'(cfg_rd_wait) : int'(cfg_cs_to_oe);
    lp = cfg_page_en ? int'(cfg_pg_wait) : last;
    if (wr) begin exp_cs = last + 1; exp_rsp = 1; end
    else begin exp_cs = last + 1 + int'(len) * (lp + 1); exp_rsp = int'(len) + 1; end
    if (cfg_ext_wait && wrel > last) begin
      e = (wrel < last + tt) ? wrel : last + tt - 1;
      exp_tmo = (wrel >= last + tt);
      exp_cs = e + 1 + ((exp_tmo || wr) ? 0 : int'(len) * (lp + 1));
      if (exp_tmo) exp_rsp = 1;
    end

    @(negedge clk);
    req_write = wr; req_len = len; req_addr = addr; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    mem_wait_n = (wrel < 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (k < 5000) begin
      if (k == wrel) mem_wait_n = 1'b1;
      cs = (mem_cs == cfg_cs_high);
      if (!mem_oe_n) exp_lane = cfg_lane_low ? ~wm : wm;
      else if (!mem_we_n) exp_lane = ~be;
      else if (cs && wr) exp_lane = 4'hF;
      else exp_lane = cfg_lane_low ? 4'hF : 4'h0;
      if (mem_lane !== exp_lane) bad_bus = 1;
      if (cs) begin
        cs_n++;
        if (!mem_oe_n && oe_f < 0) oe_f = k;
        if (!mem_we_n) begin
          if (we_f < 0) we_f = k;
          we_n++;
        end
        if (wr && (!mem_dq_oe || mem_dq_out !== wd)) bad_bus = 1;
        if (!wr && mem_dq_oe) bad_bus = 1;
      end else if (!req_ready) begin
        turn_n++;
        if (mem_dq_oe || !mem_oe_n || !mem_we_n) bad_bus = 1;
      end else begin
        break;
      end
      if (rsp_valid) begin
        exp_d = pat(addr + 16'(rsp_n * step)) & lb;
        if (!wr && rsp_rdata !== exp_d) bad_data = 1;
        if (rsp_last !== (rsp_n == exp_rsp - 1)) bad_last = 1;
        if (rsp_timeout) tmo_seen = 1;
        rsp_n++;
      end
      k++;
      @(negedge clk);
    end
    mem_wait_n = 1'b1;
    chk(k < 5000, {tag, " access finished"}, k, 5000);
    chk(cs_n == exp_cs, {tag, " chip-select length"}, cs_n, exp_cs);
    chk(turn_n == int'(cfg_turn) + 1, {tag, " R5 turnaround"}, turn_n, int'(cfg_turn) + 1);
    if (!wr) chk(oe_f == int'(cfg_cs_to_oe), {tag, " R1 OE delay"}, oe_f, int'(cfg_cs_to_oe));
    else begin
      chk(we_f == int'(cfg_cs_to_we) + 1, {tag, " R2 WE delay"}, we_f, int'(cfg_cs_to_we) + 1);
      chk(we_n == exp_cs - int'(cfg_cs_to_we) - 1, {tag, " R2 WE width"}, we_n,
          exp_cs - int'(cfg_cs_to_we) - 1);
    end
    chk(rsp_n == exp_rsp, {tag, " R11 response count"}, rsp_n, exp_rsp);
    chk(tmo_seen == exp_tmo, {tag, " R9 timeout flag"}, tmo_seen, exp_tmo);
    chk(!bad_bus, {tag, " R7 lanes/data bus"}, bad_bus, 0);
    chk(!bad_data, {tag, " R4 read data"}, bad_data, 0);
    chk(!bad_last, {tag, " R11 last flag"}, bad_last, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 200000 expected fewer cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, R6 active-low select idles high
    chk(mem_cs == 1'b1, "R12/R6 reset chip select", mem_cs, 1);
    chk(mem_oe_n && mem_we_n, "R12 reset strobes", {mem_oe_n, mem_we_n}, 3);
    chk(!mem_dq_oe, "R12 reset drive", mem_dq_oe, 0);
    chk(!rsp_valid, "R12 reset response", rsp_valid, 0);
    chk(req_ready, "R12 reset ready", req_ready, 1);
    chk(mem_lane == 4'h0, "R7 reset lanes", mem_lane, 0);

    // R1 R6 R7: single reads over delay and wait fields
    for (int d = 0; d < 5; d++) begin
      for (int r = 0; r < 5; r++) begin
        cfg_cs_to_oe = 4'(d); cfg_rd_wait = 5'(r);
        cfg_cs_high = 1'((d + r) % 2); cfg_lane_low = 1'(r % 2);
        cfg_width = 2'(d % 4); cfg_turn = 4'((3 * d + r) % 5);
        access("R1 single read", 1'b0, 2'd0, 16'(16'h0100 + 8 * r), 32'h0, 4'h0, -1);
      end
    end

    // R3 R4: multi-word reads, page mode on and off, every width
    cfg_rd_wait = 5'd4; cfg_cs_to_oe = 4'd1; cfg_turn = 4'd1; cfg_cs_high = 1'b0;
    for (int pe = 0; pe < 2; pe++) begin
      for (int n = 0; n < 4; n++) begin
        for (int pg = 0; pg < 3; pg++) begin
          cfg_page_en = 1'(pe); cfg_pg_wait = 5'(pg); cfg_width = 2'(n);
          cfg_lane_low = 1'(pg % 2);
          access("R3/R4 page read", 1'b0, 2'(n), 16'h2340, 32'h0, 4'h0, -1);
        end
      end
    end

    // R2 R7: writes over delay and wait fields
    cfg_page_en = 1'b0;
    for (int d = 0; d < 4; d++) begin
      for (int w = 0; w < 4; w++) begin
        cfg_cs_to_we = 4'(d); cfg_wr_wait = 5'(w);
        cfg_lane_low = 1'(w % 2); cfg_cs_high = 1'(d % 2); cfg_turn = 4'(w);
        access("R2 write", 1'b1, 2'd0, 16'h0400, 32'hC0DE0000 + 32'(d * 16 + w),
               4'(d * 4 + w + 1), -1);
      end
    end

    // R8 R9: wait stretch and timeout around the boundary (last index 2, limit 16)
    cfg_ext_wait = 1'b1; cfg_wait_to = 10'd0; cfg_rd_wait = 5'd2; cfg_cs_to_oe = 4'd1;
    cfg_cs_high = 1'b1; cfg_lane_low = 1'b0; cfg_width = 2'd2; cfg_turn = 4'd2;
    access("R8 wait high", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, -1);
    access("R8 release at 0", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 0);
    access("R8 release on last", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 2);
    access("R8 stretch 5", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 5);
    access("R8 release just in time", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 17);
    access("R9 release too late", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 18);
    access("R9 never released", 1'b0, 2'd0, 16'h0800, 32'h0, 4'h0, 1000);
    access("R8 stretched page read", 1'b0, 2'd3, 16'h0800, 32'h0, 4'h0, 6);
    access("R9 burst dropped", 1'b0, 2'd3, 16'h0800, 32'h0, 4'h0, 1000);
    cfg_cs_to_we = 4'd1; cfg_wr_wait = 5'd1;
    access("R8 stretched write", 1'b1, 2'd0, 16'h0900, 32'h12345678, 4'h9, 9);
    access("R9 write timeout", 1'b1, 2'd0, 16'h0900, 32'h12345678, 4'h6, 1000);
    cfg_wait_to = 10'd2;
    access("R9 timeout 48", 1'b0, 2'd0, 16'h0A00, 32'h0, 4'h0, 1000);
    access("R8 release at 49", 1'b0, 2'd0, 16'h0A00, 32'h0, 4'h0, 49);

    // R10: wait ignored when extended wait is off
    cfg_ext_wait = 1'b0;
    access("R10 wait ignored read", 1'b0, 2'd2, 16'h0B00, 32'h0, 4'h0, 1000);
    access("R10 wait ignored write", 1'b1, 2'd0, 16'h0B00, 32'hA5A5A5A5, 4'hF, 1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule